// File: doc/BRIEF.md
# Four-Channel Attenuating Sample Mixer

This block combines four channels of decoded signed samples into a single 12-bit word for a digital-to-analog converter. A fixed divider derives a sample tick from the system clock, one tick every `DIV` clocks (136 by default). The tick sets the sample rate: 8 kHz at a 1.088 MHz clock, or 32 kHz at 4.352 MHz. On each tick the block captures all four samples. Each sample is scaled by its channel's attenuation code, which selects a gain in steps of about -3 dB, from 0 dB down to -24 dB. The four scaled values are then added at full precision, clamped to the signed 12-bit range and converted to offset binary.

A channel with its active flag low adds nothing to the sum. The upstream decoders learn when their samples are taken from `tick_o`. Samples, codes and flags only need to be stable in the cycle in which `tick_o` is high.

The output is a plain valid strobe with no ready input, because a converter accepts every word at the sample rate. The stream therefore has no back-pressure. `dac_word_o` holds its value between strobes, so a consumer may latch it at any time until the next strobe.

Top module: `quad_gain_mixer`

## Requirements
- R1: An attenuation code k from 0 to 8 selects the gain g = round(10^(-3k/20) * 32768). The channel's share of the sum is floor(sample * g / 32768). Channel i takes its sample from `smp_i[12i+11:12i]` and its code from `code_i[4i+3:4i]`.
- R2: Code 0 passes the captured sample through unchanged.
- R3: Codes 9 to 15 give exactly the same result as code 8 (-24 dB).
- R4: The sum of the four shares is clamped to the range -2048 to 2047. A sum above 2047 gives 2047, and a sum below -2048 gives -2048.
- R5: A channel whose bit in `act_i` is 0 adds zero to the sum, whatever its sample and code.
- R6: `tick_o` is high for exactly one clock in every `DIV` clocks.
- R7: `dac_valid_o` is high for exactly one clock, two clocks after each `tick_o` pulse. `dac_word_o` reflects the inputs present while `tick_o` was high. Input changes at any other time have no effect on the word, which holds until the next strobe.
- R8: `dac_word_o` is the clamped signed sum with its most significant bit inverted, so zero is 12'h800. During reset `dac_word_o` is 12'h800 and both `tick_o` and `dac_valid_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_i | input | 48 | Four signed 12-bit samples, channel 0 in the low bits |
| code_i | input | 16 | Four 4-bit attenuation codes, channel 0 in the low bits |
| act_i | input | 4 | Per-channel active flags |
| tick_o | output | 1 | Sample tick; the inputs are captured while it is high |
| dac_word_o | output | 12 | Mixed output word in offset binary |
| dac_valid_o | output | 1 | One-clock strobe marking a new output word |

## Verification
The bench builds the block with its default parameters: four channels, 12-bit samples, 4-bit codes and a divider of 136. With these values the real sample period can be measured exactly edge to edge, and every attenuation code from 0 to 15 can be applied. Full-scale inputs on all four channels can push the sum past both clamp limits. The expected gains are computed in the bench with real-number powers of ten, so the stored table in the design is checked against the decibel formula and not against itself.

// File: rtl/qgm_pkg.sv
package qgm_pkg;
  localparam int GAIN_W    = 16;
  localparam int GAIN_FRAC = 15;
  localparam int LEVELS    = 9;

  // Q1.15 gain for a -3 dB step index (0 dB at index 0)
  function automatic logic [GAIN_W-1:0] gain_of(input int k);
    case (k)
      0:       gain_of = 16'd32768;
      1:       gain_of = 16'd23198;
      2:       gain_of = 16'd16423;
      3:       gain_of = 16'd11627;
      4:       gain_of = 16'd8231;
      5:       gain_of = 16'd5827;
      6:       gain_of = 16'd4125;
      7:       gain_of = 16'd2920;
      default: gain_of = 16'd2068;
    endcase
  endfunction
endpackage

// File: rtl/qgm_tick.sv
module qgm_tick #(
  parameter int DIV = 136
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CNT_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == LAST) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end

  generate
    if (DIV > 1) begin : g_chk
      assert_tick_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
      assert_tick_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> cnt == '0);
    end
  endgenerate
endmodule

// File: rtl/qgm_chan.sv
module qgm_chan
  import qgm_pkg::*;
#(
  parameter int SW = 12,
  parameter int CW = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cap,
  input  logic signed [SW-1:0] sample,
  input  logic [CW-1:0]        code,
  input  logic                 act,
  output logic signed [SW-1:0] share
);
  localparam int MAXK = LEVELS - 1;
  localparam int PW   = SW + GAIN_W + 1;

  int                  k;
  logic [GAIN_W-1:0]   g;
  logic signed [PW-1:0] wide;
  logic signed [PW-1:0] scaled;

  always_comb begin
    k      = (int'(code) > MAXK) ? MAXK : int'(code);
    g      = gain_of(k);
    wide   = sample * $signed({1'b0, g});
    scaled = wide >>> GAIN_FRAC;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)   share <= '0;
    else if (cap) share <= act ? scaled[SW-1:0] : '0;
  end

  logic signed [SW:0] mag_now, mag_in;
  always_comb begin
    mag_now = share[SW-1] ? -{share[SW-1], share} : {share[SW-1], share};
    mag_in  = sample[SW-1] ? -{sample[SW-1], sample} : {sample[SW-1], sample};
  end

  assert_off_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cap && !act |=> share == '0);
  assert_unity_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cap && act && code == '0 |=> share == $past(sample));
  assert_no_gain_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cap && act |=> mag_now <= $past(mag_in));
endmodule

// File: rtl/qgm_sum.sv
module qgm_sum #(
  parameter int NCH = 4,
  parameter int SW  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_vld,
  input  logic [NCH*SW-1:0] parts,
  output logic [SW-1:0]     word,
  output logic              valid
);
  localparam int AW = SW + $clog2(NCH) + 1;
  localparam logic signed [AW-1:0] HI = AW'((1 << (SW - 1)) - 1);
  localparam logic signed [AW-1:0] LO = -HI - 1;

  logic signed [AW-1:0] acc;
  logic signed [SW-1:0] sat;

  always_comb begin
    acc = '0;
    for (int i = 0; i < NCH; i++) begin
      acc = acc + {{(AW-SW){parts[i*SW+SW-1]}}, parts[i*SW +: SW]};
    end
    if (acc > HI)      sat = HI[SW-1:0];
    else if (acc < LO) sat = LO[SW-1:0];
    else               sat = acc[SW-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word  <= {1'b1, {(SW-1){1'b0}}};
      valid <= 1'b0;
    end else begin
      valid <= in_vld;
      if (in_vld) word <= {~sat[SW-1], sat[SW-2:0]};
    end
  end

  assert_clamp_hi_R4: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld && acc > HI |=> word == {SW{1'b1}});
  assert_clamp_lo_R4: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld && acc < LO |=> word == '0);
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> $stable(word) && !valid);
endmodule

// File: rtl/quad_gain_mixer.sv
module quad_gain_mixer #(
  parameter int NCH = 4,
  parameter int SW  = 12,
  parameter int CW  = 4,
  parameter int DIV = 136
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH*SW-1:0] smp_i,
  input  logic [NCH*CW-1:0] code_i,
  input  logic [NCH-1:0]    act_i,
  output logic              tick_o,
  output logic [SW-1:0]     dac_word_o,
  output logic              dac_valid_o
);
  logic              cap_vld;
  logic [NCH*SW-1:0] shares;

  qgm_tick #(.DIV(DIV)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (tick_o)
  );

  generate
    for (genvar i = 0; i < NCH; i++) begin : g_ch
      logic signed [SW-1:0] sh;
      qgm_chan #(.SW(SW), .CW(CW)) u_ch (
        .clk   (clk),
        .rst_n (rst_n),
        .cap   (tick_o),
        .sample(smp_i[i*SW +: SW]),
        .code  (code_i[i*CW +: CW]),
        .act   (act_i[i]),
        .share (sh)
      );
      assign shares[i*SW +: SW] = sh;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) cap_vld <= 1'b0;
    else        cap_vld <= tick_o;
  end

  qgm_sum #(.NCH(NCH), .SW(SW)) u_sum (
    .clk   (clk),
    .rst_n (rst_n),
    .in_vld(cap_vld),
    .parts (shares),
    .word  (dac_word_o),
    .valid (dac_valid_o)
  );

  assert_valid_after_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dac_valid_o |-> $past(tick_o, 2));
  assert_valid_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dac_valid_o |=> !dac_valid_o);
endmodule

// File: tb/tb_quad_gain_mixer.sv
module tb_quad_gain_mixer;
  localparam int NCH = 4;
  localparam int SW  = 12;
  localparam int CW  = 4;
  localparam int DIV = 136;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NCH*SW-1:0] smp_i = '0;
  logic [NCH*CW-1:0] code_i = '0;
  logic [NCH-1:0]    act_i = '0;
  logic              tick_o;
  logic [SW-1:0]     dac_word_o;
  logic              dac_valid_o;

  quad_gain_mixer #(.NCH(NCH), .SW(SW), .CW(CW), .DIV(DIV)) dut (
    .clk(clk), .rst_n(rst_n), .smp_i(smp_i), .code_i(code_i), .act_i(act_i),
    .tick_o(tick_o), .dac_word_o(dac_word_o), .dac_valid_o(dac_valid_o)
  );

  always #5 clk = ~clk;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  int s[NCH];
  int c[NCH];
  int a[NCH];

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      bad = bad + 1;
      $display("FAIL watchdog: actual cycles=%0d expected below 150000", cyc);
      finish_run();
    end
  end

  task automatic check(input string req, input int act, input int exp);
    total = total + 1;
    if (act != exp) begin
      bad = bad + 1;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int gain(input int k);
    real r;
    r = (10.0 ** (-3.0 * k / 20.0)) * 32768.0;
    return $rtoi(r + 0.5);
  endfunction

  function automatic int share(input int smp, input int code);
    int k;
    int p;
    k = (code > 8) ? 8 : code;
    p = smp * gain(k);
    return p >>> 15;
  endfunction

  function automatic int model();
    int sum = 0;
    for (int i = 0; i < NCH; i++) if (a[i] != 0) sum += share(s[i], c[i]);
    if (sum > 2047)  sum = 2047;
    if (sum < -2048) sum = -2048;
    return (sum & 12'hFFF) ^ 12'h800;
  endfunction

  task automatic wait_valid();
    int n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!dac_valid_o && n < 4 * DIV);
  endtask

  task automatic drive();
    for (int i = 0; i < NCH; i++) begin
      smp_i[i*SW +: SW] = SW'(s[i]);
      code_i[i*CW +: CW] = CW'(c[i]);
      act_i[i] = (a[i] != 0);
    end
  endtask

  // present the inputs right after a strobe and return the next word
  task automatic run(output int w);
    wait_valid();
    drive();
    wait_valid();
    w = int'(dac_word_o);
  endtask

  task automatic set4(input int s0, s1, s2, s3, c0, c1, c2, c3, a0, a1, a2, a3);
    s[0] = s0; s[1] = s1; s[2] = s2; s[3] = s3;
    c[0] = c0; c[1] = c1; c[2] = c2; c[3] = c3;
    a[0] = a0; a[1] = a1; a[2] = a2; a[3] = a3;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check("R8 reset word", int'(dac_word_o), 12'h800);
    check("R8 reset valid", int'(dac_valid_o), 0);
    check("R8 reset tick", int'(tick_o), 0);
  endtask

  task automatic t_unity();
    int w;
    set4(-777, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0);
    run(w);
    check("R2 single unity", w, ((-777) & 12'hFFF) ^ 12'h800);
    set4(5, -3, 100, -200, 0, 0, 0, 0, 1, 1, 1, 1);
    run(w);
    check("R2 four unity", w, ((-98) & 12'hFFF) ^ 12'h800);
  endtask

  task automatic t_steps();
    int w;
    for (int k = 0; k < 9; k++) begin
      set4(0, 1500, 0, 0, 0, k, 0, 0, 0, 1, 0, 0);
      run(w);
      check($sformatf("R1 step %0d pos", k), w, model());
      set4(0, 0, -1001, 0, 0, 0, k, 0, 0, 0, 1, 0);
      run(w);
      check($sformatf("R1 step %0d neg", k), w, model());
    end
  endtask

  task automatic t_clamp_code();
    int w, ref8;
    set4(0, 0, 0, 2000, 0, 0, 0, 8, 0, 0, 0, 1);
    run(ref8);
    check("R3 code 8 ref", ref8, model());
    for (int k = 9; k < 16; k++) begin
      set4(0, 0, 0, 2000, 0, 0, 0, k, 0, 0, 0, 1);
      run(w);
      check($sformatf("R3 code %0d", k), w, ref8);
    end
  endtask

  task automatic t_inactive();
    int w;
    set4(2047, -2048, 900, 2047, 0, 0, 3, 0, 0, 0, 1, 0);
    run(w);
    check("R5 one active", w, model());
    set4(2047, -2048, 900, -5, 0, 0, 0, 0, 0, 0, 0, 0);
    run(w);
    check("R5 none active", w, 12'h800);
  endtask

  task automatic t_sat();
    int w;
    set4(2047, 2047, 2047, 2047, 0, 0, 0, 0, 1, 1, 1, 1);
    run(w);
    check("R4 full pos", w, 12'hFFF);
    set4(-2048, -2048, -2048, -2048, 0, 0, 0, 0, 1, 1, 1, 1);
    run(w);
    check("R4 full neg", w, 12'h000);
    set4(1024, 1024, 0, 0, 0, 0, 0, 0, 1, 1, 0, 0);
    run(w);
    check("R4 just over", w, 12'hFFF);
    set4(2000, 47, 0, 0, 0, 0, 0, 0, 1, 1, 0, 0);
    run(w);
    check("R4 exact max", w, 12'hFFF);
    set4(-1024, -1025, 0, 0, 0, 0, 0, 0, 1, 1, 0, 0);
    run(w);
    check("R4 just under", w, 12'h000);
    set4(2047, -2048, 2047, -2048, 0, 0, 0, 0, 1, 1, 1, 1);
    run(w);
    check("R4 cancel", w, 12'h7FE);
  endtask

  task automatic t_offset();
    int w;
    set4(-1, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0);
    run(w);
    check("R8 minus one", w, 12'h7FF);
    set4(1, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0);
    run(w);
    check("R8 plus one", w, 12'h801);
  endtask

  task automatic t_timing();
    int n, w0, tk1, tk2, tk3;
    set4(300, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0);
    wait_valid();
    drive();
    wait_valid();
    w0 = int'(dac_word_o);
    check("R7 word", w0, model());
    // change inputs mid-period: word must hold
    s[0] = -300;
    drive();
    n = 0;
    tk1 = 0; tk2 = 0; tk3 = 0;
    do begin
      @(negedge clk);
      n++;
      tk3 = tk2; tk2 = tk1; tk1 = int'(tick_o);
      if (n == 1) check("R7 strobe width", int'(dac_valid_o), 0);
      if (n == 60) check("R7 hold mid period", int'(dac_word_o), w0);
    end while (!dac_valid_o && n < 4 * DIV);
    check("R6 period", n, DIV);
    check("R7 tick two before", tk3, 1);
    check("R7 tick not one before", tk2, 0);
    check("R7 new word", int'(dac_word_o), model());
  endtask

  initial begin
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    t_unity();
    t_steps();
    t_clamp_code();
    t_inactive();
    t_sat();
    t_offset();
    t_timing();
    finish_run();
  end
endmodule